// File: doc/BRIEF.md
# One-Bit Control Processor Core

This block is the execution core of a bit-serial control processor. Each cycle it may accept one instruction byte from an external sequencer. It can copy a single bit of an 8-bit input bus into a one-bit result register. It can also write that result, or its inverse, into one addressed bit of an 8-bit output latch. A jump instruction raises a flag that tells the sequencer to restart its program. The program counter and program storage are outside the block.

A typical program step loads an input bit that is known to be zero. It then writes each output bit in turn: a plain store gives a 0 and an inverting store gives a 1. Output bit 7 acts as a strobe. The program sets it with an inverting store and then clears it with a plain store, once bits 0 to 6 already hold the data.

Instructions arrive on a valid/ready interface. An instruction is consumed on a rising clock edge where both `instr_valid` and `instr_ready` are high. `instr_ready` is low while reset is applied. It goes high on the first edge without reset and then stays high, so the block never pushes back on the sequencer during operation. The sequencer may hold `instr_valid` low for any number of cycles. While it is low, nothing changes.

Top module: `onebit_ctrl_core`

## Requirements
- R1: While `rst` is high, on each clock edge the result register, the output latch, `jump_flag` and `instr_ready` all become 0.
- R2: An accepted instruction whose bits [7:4] are 0001 copies `in_bus[instr_data[2:0]]` into the result register. The new value is visible on `result_bit` after that edge. This happens whatever the value of bit 3.
- R3: An accepted instruction with bits [7:4] = 1000 and bit 3 = 1 writes the result register into output bit `instr_data[2:0]`. The other seven output bits keep their values.
- R4: An accepted instruction with bits [7:4] = 1001 and bit 3 = 1 writes the inverse of the result register into output bit `instr_data[2:0]`. The other seven output bits keep their values.
- R5: A store (opcode 1000 or 1001) with bit 3 = 0 leaves the output latch unchanged.
- R6: An accepted instruction with bits [7:4] = 1100 makes `jump_flag` high for the cycle after the accepting edge. `jump_flag` is low after any edge that accepts a different instruction or accepts nothing.
- R7: An accepted instruction whose opcode is none of 0001, 1000, 1001 or 1100 leaves the result register and the output latch unchanged.
- R8: On an edge where `instr_valid` is low, the result register and the output latch keep their values.
- R9: `instr_ready` is high on every cycle after the first edge without reset.
- R10: A step that writes bit 7 with an inverting store and then with a plain store, after loading a zero, gives a one-cycle high pulse on `out_reg[7]`. Bits 0 to 6 keep the character written before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction byte is present |
| instr_ready | output | 1 | Core accepts an instruction this cycle |
| instr_data | input | 8 | Instruction: [7:4] opcode, [3] I/O select, [2:0] bit address |
| in_bus | input | 8 | Addressable input bits |
| out_reg | output | 8 | Addressable output latch |
| result_bit | output | 1 | Current value of the one-bit result register |
| jump_flag | output | 1 | One-cycle request to restart the program |

## Verification
The hardest case to reach from the ports is a store that must leave seven bits alone. This can only be checked once the latch holds a mixed pattern and the result register holds a known value. The random stream therefore interleaves loads from a random input bus with stores to random addresses. This builds up varied latch contents before each store is checked against a bench model. Directed sequences add the full character step with its strobe pulse, stores with the I/O select bit cleared, unused opcodes, idle cycles and back-to-back jumps.

// File: rtl/onebit_pkg.sv
package onebit_pkg;

  typedef enum logic [3:0] {
    OP_LOAD   = 4'b0001,
    OP_STORE  = 4'b1000,
    OP_STOREN = 4'b1001,
    OP_JUMP   = 4'b1100
  } opcode_e;

  typedef struct packed {
    logic load;
    logic store;
    logic store_inv;
    logic jump;
  } cmd_t;

endpackage

// File: rtl/onebit_decode.sv
module onebit_decode
  import onebit_pkg::*;
#(
  parameter int ADDR_W  = 3,
  localparam int INSTR_W = 5 + ADDR_W
) (
  input  logic               accept,
  input  logic [INSTR_W-1:0] instr,
  output cmd_t               cmd,
  output logic [ADDR_W-1:0]  addr
);

  logic [3:0] opc;
  logic       io_sel;

  assign opc    = instr[INSTR_W-1 -: 4];
  assign io_sel = instr[ADDR_W];
  assign addr   = instr[ADDR_W-1:0];

  always_comb begin
    cmd = '0;
    if (accept) begin
      unique case (opc)
        OP_LOAD:   cmd.load      = 1'b1;
        OP_STORE:  cmd.store     = io_sel;
        OP_STOREN: cmd.store_inv = io_sel;
        OP_JUMP:   cmd.jump      = 1'b1;
        default:   cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/onebit_result_reg.sv
module onebit_result_reg #(
  parameter int PORT_W = 8,
  localparam int ADDR_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PORT_W-1:0] in_bus,
  input  logic [ADDR_W-1:0] addr,
  output logic              rr
);

  always_ff @(posedge clk) begin
    if (rst)       rr <= 1'b0;
    else if (load) rr <= in_bus[addr];
  end

  // R2: a load copies the addressed input bit
  assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> rr == $past(in_bus[addr]));

  // R7, R8: without a load the result bit holds
  assert_rr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(rr));

endmodule

// File: rtl/onebit_out_latch.sv
module onebit_out_latch #(
  parameter int PORT_W = 8,
  localparam int ADDR_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_val,
  input  logic [ADDR_W-1:0] addr,
  output logic [PORT_W-1:0] q
);

  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(b));
    always_ff @(posedge clk) begin
      if (rst)      q[b] <= 1'b0;
      else if (hit) q[b] <= wr_val;
    end
  end

  // R3, R4: only the addressed bit may move on a write
  assert_write_mask_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q ^ $past(q)) & ~(PORT_W'(1) << $past(addr))) == '0);

  // R3, R4: the addressed bit takes the written value
  assert_write_value_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> q[$past(addr)] == $past(wr_val));

  // R5, R7, R8: no write, no change
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/onebit_ctrl_core.sv
module onebit_ctrl_core
  import onebit_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int ADDR_W  = $clog2(PORT_W),
  localparam int INSTR_W = 5 + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_data,
  input  logic [PORT_W-1:0]  in_bus,
  output logic [PORT_W-1:0]  out_reg,
  output logic               result_bit,
  output logic               jump_flag
);

  logic              accept;
  cmd_t              cmd;
  logic [ADDR_W-1:0] addr;
  logic              rr;

  assign accept = instr_valid && instr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_ready <= 1'b0;
      jump_flag   <= 1'b0;
    end else begin
      instr_ready <= 1'b1;
      jump_flag   <= cmd.jump;
    end
  end

  onebit_decode #(.ADDR_W(ADDR_W)) u_decode (
    .accept (accept),
    .instr  (instr_data),
    .cmd    (cmd),
    .addr   (addr)
  );

  onebit_result_reg #(.PORT_W(PORT_W)) u_rr (
    .clk    (clk),
    .rst    (rst),
    .load   (cmd.load),
    .in_bus (in_bus),
    .addr   (addr),
    .rr     (rr)
  );

  onebit_out_latch #(.PORT_W(PORT_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cmd.store || cmd.store_inv),
    .wr_val (cmd.store_inv ? ~rr : rr),
    .addr   (addr),
    .q      (out_reg)
  );

  assign result_bit = rr;

  // R6: an accepted jump raises the flag on the next cycle
  assert_jump_set_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && instr_data[INSTR_W-1 -: 4] == OP_JUMP) |=> jump_flag);

  // R6: anything else leaves the flag low
  assert_jump_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !(accept && instr_data[INSTR_W-1 -: 4] == OP_JUMP) |=> !jump_flag);

  // R5: a store with I/O select cleared leaves the latch as it was
  assert_io_off_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !instr_data[ADDR_W]) |=> $stable(out_reg));

  // R9: ready stays high once out of reset
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (rst)
    instr_ready |=> instr_ready);

endmodule

// File: tb/test_onebit_ctrl_core.sv
module test_onebit_ctrl_core;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic       instr_ready;
  logic [7:0] instr_data = '0;
  logic [7:0] in_bus = '0;
  logic [7:0] out_reg;
  logic       result_bit;
  logic       jump_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_out = '0;
  logic       m_rr = 1'b0;
  logic       m_jmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onebit_ctrl_core i_onebit_ctrl_core (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_data(instr_data), .in_bus(in_bus), .out_reg(out_reg),
    .result_bit(result_bit), .jump_flag(jump_flag)
  );

  function automatic logic [7:0] f_out(logic [7:0] o, logic r, logic [7:0] ins);
    if (ins[3]) begin
      if (ins[7:4] == 4'b1000) o[ins[2:0]] = r;
      if (ins[7:4] == 4'b1001) o[ins[2:0]] = ~r;
    end
    return o;
  endfunction

  function automatic logic f_rr(logic r, logic [7:0] ins, logic [7:0] bus);
    return (ins[7:4] == 4'b0001) ? bus[ins[2:0]] : r;
  endfunction

  function automatic string f_tag(logic v, logic [7:0] ins);
    if (!v) return "R8";
    case (ins[7:4])
      4'b0001: return "R2";
      4'b1000: return ins[3] ? "R3" : "R5";
      4'b1001: return ins[3] ? "R4" : "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic [7:0] ins, logic [7:0] bus);
    string tag;
    instr_valid = v;
    instr_data  = ins;
    in_bus      = bus;
    tag = f_tag(v, ins);
    @(posedge clk);
    #1;
    if (v) begin
      m_out = f_out(m_out, m_rr, ins);
      m_rr  = f_rr(m_rr, ins, bus);
    end
    m_jmp = v && ins[7:4] == 4'b1100;
    check({tag, " out"}, 32'(out_reg), 32'(m_out));
    check({tag, " rr"}, 32'(result_bit), 32'(m_rr));
    check({tag, " jump"}, 32'(jump_flag), 32'(m_jmp));
    check("R9 ready", 32'(instr_ready), 32'd1);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic send_char(logic [7:0] ch);
    logic [7:0] lo;
    step(1'b1, 8'h19, 8'h00);
    for (int b = 0; b < 7; b++)
      step(1'b1, {3'b100, ch[b], 1'b1, 3'(b)}, 8'h00);
    step(1'b1, 8'h9F, 8'h00);
    check("R10 strobe high", 32'(out_reg[7]), 32'd1);
    lo = out_reg;
    check("R10 data bits", 32'(lo[6:0]), 32'(ch[6:0]));
    step(1'b1, 8'h8F, 8'h00);
    check("R10 strobe low", 32'(out_reg), 32'({1'b0, ch[6:0]}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    instr_valid = 1'b1;
    instr_data  = 8'h9F;
    repeat (3) @(negedge clk);
    check("R1 out", 32'(out_reg), 32'd0);
    check("R1 rr", 32'(result_bit), 32'd0);
    check("R1 jump", 32'(jump_flag), 32'd0);
    check("R1 ready", 32'(instr_ready), 32'd0);
    instr_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R9 ready after reset", 32'(instr_ready), 32'd1);
    @(negedge clk);

    send_char(8'h48);
    send_char(8'h65);
    send_char(8'h0D);

    step(1'b1, 8'h1B, 8'hFF);
    step(1'b1, 8'h82, 8'h00);
    step(1'b1, 8'h95, 8'h00);
    check("R5 io off keeps latch", 32'(out_reg), 32'h0D);
    step(1'b1, 8'h2C, 8'h00);
    step(1'b1, 8'hF9, 8'h00);
    step(1'b1, 8'h03, 8'h00);
    check("R7 unused opcodes", 32'(result_bit), 32'd1);
    step(1'b0, 8'h18, 8'h00);
    step(1'b0, 8'h8A, 8'h00);
    check("R8 idle keeps rr", 32'(result_bit), 32'd1);
    step(1'b1, 8'hC8, 8'h00);
    step(1'b1, 8'hC0, 8'h00);
    step(1'b1, 8'h00, 8'h00);
    check("R6 jump one cycle", 32'(jump_flag), 32'd0);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] ins;
      logic [3:0] opc;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: opc = 4'b0001;
        3, 4:    opc = 4'b1000;
        5, 6:    opc = 4'b1001;
        7:       opc = 4'b1100;
        default: opc = 4'($urandom);
      endcase
      ins = {opc, 1'($urandom_range(0, 3) != 0), 3'($urandom)};
      step($urandom_range(0, 4) != 0, ins, 8'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule